// File: doc/BRIEF.md
# Iterative DES Cipher Engine

This block runs the Data Encryption Standard one Feistel round per enabled clock. A 64-bit key and a 64-bit data word are taken in at the first enabled edge of a block. Sixteen enabled edges later, the encrypted or decrypted word appears on the output, and a valid strobe is raised for one cycle. Blocks are handled independently, in electronic-codebook style. The direction select must stay steady for the whole of a block.

Holding the enable low freezes every piece of round state for as long as the enable stays low. A synchronous clear throws away the block in flight, so a fresh key and data word can start on the next enabled edge. An odd-parity checker on the key bytes can be switched on. It reports a mismatch through a flag and has no effect on the cipher result.

Top module: `des_engine`

## Requirements
- R1: With `enc_sel` = 1, the result equals standard DES encryption of `data_in` under `key_in`. DES bit 1 of every 64-bit bus is port bit [63] and DES bit 64 is port bit [0].
- R2: With `enc_sel` = 0, the result equals standard DES decryption of `data_in` under `key_in`, using the same bit numbering as R1.
- R3: `out_valid` rises after the 16th enabled edge of a block and stays high for exactly one cycle. `data_out` changes only at a block completion or a clear, and holds its value in between.
- R4: Key port bits [56], [48], [40], [32], [24], [16], [8] and [0] (the low bit of each byte) have no effect on the result.
- R5: `par_err` is high exactly when `par_chk_en` is 1 and at least one key byte holds an even number of ones. The path from `key_in` to `par_err` is combinational.
- R6: While `en` is 0, the round position and all intermediate state hold and `out_valid` stays 0. Raising `en` again continues from the same round.
- R7: `clr` = 1 at an edge takes priority over `en`. It returns the round position to zero, drives `out_valid` low and zeroes `data_out`. The next enabled edge with `clr` low starts a new block.
- R8: `key_in` and `data_in` are sampled only at the first enabled edge of a block. Later changes have no effect on that block.
- R9: With `en` held high, a new block starts at the edge right after a completion, giving one result every 16 cycles.
- R10: `rst_n` = 0 asynchronously clears the round position, `out_valid` and `data_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all state |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Advance one round per edge when high; pause when low |
| clr | input | 1 | Synchronous abort of the current block |
| enc_sel | input | 1 | 1 = encrypt, 0 = decrypt |
| par_chk_en | input | 1 | Enables the key odd-parity check |
| key_in | input | 64 | Cipher key; bit [63] is DES bit 1 |
| data_in | input | 64 | Plaintext or ciphertext word |
| data_out | output | 64 | Result word, held between completions |
| out_valid | output | 1 | One-cycle strobe marking a new result |
| par_err | output | 1 | Key parity mismatch flag |

## Verification
Known-answer vectors are run in both directions.

- A design that reversed the bit order or got a table entry wrong returns a different word.
- A decrypt schedule that rotated in its first round corrupts every decryption.

The bench pauses a block midway and changes the key and data while it is paused.

- A design that kept counting during the pause fires the strobe too early.
- A design that re-sampled its inputs during the pause produces a wrong word.

A block is also aborted with a clear and restarted, and another block is cut short by reset. Each of these must leave no residue in the next result.

The bench also runs back-to-back blocks and flips the parity bits of the key. A counter that wraps in the wrong place misplaces the second strobe. A key schedule that read a parity bit changes the result.

// File: rtl/des_pkg.sv
// des_pkg: shared sizes, types, permutation tables and substitution boxes
// for the iterative DES engine. Bit numbering: DES bit n (1 = MSB) of a
// W-bit vector sits at index W-n. Table entries are 1-based DES positions.
package des_pkg;

    localparam int BLK_W      = 64;
    localparam int HALF_W     = BLK_W / 2;
    localparam int KEY_W      = 64;
    localparam int CD_W       = 28;
    localparam int PC1_W      = 2 * CD_W;
    localparam int SUBKEY_W   = 48;
    localparam int NUM_ROUNDS = 16;
    localparam int RND_W      = $clog2(NUM_ROUNDS);
    localparam int NUM_SBOX   = 8;
    localparam int SBOX_IN_W  = 6;
    localparam int SBOX_OUT_W = 4;
    localparam int BYTE_W     = 8;
    localparam int NUM_BYTES  = KEY_W / BYTE_W;

    typedef logic [RND_W-1:0] rnd_t;
    typedef logic [1:0]       rot_t;

    // Round-function output permutation (1-based sources).
    localparam int P_TAB [32] = '{
        16, 7, 20, 21, 29, 12, 28, 17, 1, 15, 23, 26, 5, 18, 31, 10,
        2, 8, 24, 14, 32, 27, 3, 9, 19, 13, 30, 6, 22, 11, 4, 25
    };

    // Key selection that drops the per-byte parity bits.
    localparam int PC1_TAB [56] = '{
        57, 49, 41, 33, 25, 17, 9, 1, 58, 50, 42, 34, 26, 18,
        10, 2, 59, 51, 43, 35, 27, 19, 11, 3, 60, 52, 44, 36,
        63, 55, 47, 39, 31, 23, 15, 7, 62, 54, 46, 38, 30, 22,
        14, 6, 61, 53, 45, 37, 29, 21, 13, 5, 28, 20, 12, 4
    };

    // Round-key compression from the 56-bit rotated halves.
    localparam int PC2_TAB [48] = '{
        14, 17, 11, 24, 1, 5, 3, 28, 15, 6, 21, 10,
        23, 19, 12, 4, 26, 8, 16, 7, 27, 20, 13, 2,
        41, 52, 31, 37, 47, 55, 30, 40, 51, 45, 33, 48,
        44, 49, 39, 56, 34, 53, 46, 42, 50, 36, 29, 32
    };

    // Substitution boxes: 64 nibbles each, index {b1,b6,b2..b5}, first nibble at MSB.
    localparam logic [0:NUM_SBOX-1][255:0] SBOX_TAB = {
        {64'hE4D12FB83A6C5907, 64'h0F74E2D1A6CB9538, 64'h41E8D62BFC973A50, 64'hFC8249175B3EA06D},
        {64'hF18E6B34972DC05A, 64'h3D47F28EC01A69B5, 64'h0E7BA4D158C6932F, 64'hD8A13F42B67C05E9},
        {64'hA09E63F51DC7B428, 64'hD70934A6285ECBF1, 64'hD6498F30B12C5AE7, 64'h1AD069874FE3B52C},
        {64'h7DE3069A1285BC4F, 64'hD8B56F03472C1AE9, 64'hA690CB7DF13E5284, 64'h3F06A1D8945BC72E},
        {64'h2C417AB6853FD0E9, 64'hEB2C47D150FA3986, 64'h421BAD78F9C5630E, 64'hB8C71E2D6F09A453},
        {64'hC1AF92680D34E75B, 64'hAF427C9561DE0B38, 64'h9EF528C3704A1DB6, 64'h432C95FABE17608D},
        {64'h4B2EF08D3C975A61, 64'hD0B7491AE35C2F86, 64'h14BDC37EAF680592, 64'h6BD814A7950FE23C},
        {64'hD2846FB1A93E50C7, 64'h1FD8A374C56B0E92, 64'h7B419CE206ADF358, 64'h21E74A8DFC90356B}
    };

    // Source position of output bit j (1-based) of the initial permutation.
    function automatic int ip_src(input int j);
        int row;
        int col;
        int base;
        row  = (j - 1) / 8;
        col  = (j - 1) % 8;
        base = (row < 4) ? (58 + 2 * row) : (57 + 2 * (row - 4));
        return base - 8 * col;
    endfunction

    // Source position of output bit k (1-based) of the 32-to-48 expansion.
    function automatic int e_src(input int k);
        int grp;
        int pos;
        int n;
        grp = (k - 1) / 6;
        pos = (k - 1) % 6;
        n   = 4 * grp + pos - 1;
        return ((n + 32) % 32) + 1;
    endfunction

    // Left-rotate amount of the encrypt schedule for 0-based round idx.
    function automatic rot_t rot_amount(input rnd_t idx);
        if (idx == RND_W'(0) || idx == RND_W'(1) || idx == RND_W'(8) || idx == RND_W'(15))
            return 2'd1;
        return 2'd2;
    endfunction

    // Substitution lookup for box number box.
    function automatic logic [SBOX_OUT_W-1:0] sbox_lookup(input logic [2:0] box,
                                                          input logic [SBOX_IN_W-1:0] six);
        logic [5:0] idx;
        idx = {six[5], six[0], six[4:1]};
        return SBOX_TAB[box][{~idx, 2'b00} +: 4];
    endfunction

endpackage

// File: rtl/des_ctrl.sv
// des_ctrl: round position counter for the iterative engine.
// Advances once per enabled edge and wraps after the last round. A
// synchronous clear wins over enable. Assumes NUM_ROUNDS is a power of two
// or that the wrap compare below covers it.
module des_ctrl
    import des_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic clr,
    output rnd_t rnd_idx,
    output logic first_rnd,
    output logic last_rnd
);

    localparam rnd_t LAST_IDX = rnd_t'(NUM_ROUNDS - 1);

    rnd_t rnd_q;

    // Round position: clear to zero, step when enabled, wrap after the last round.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rnd_q <= '0;
        end else if (clr) begin
            rnd_q <= '0;
        end else if (en) begin
            rnd_q <= (rnd_q == LAST_IDX) ? '0 : rnd_q + rnd_t'(1);
        end
    end

    assign rnd_idx   = rnd_q;
    assign first_rnd = (rnd_q == '0);
    assign last_rnd  = (rnd_q == LAST_IDX);

endmodule

// File: rtl/des_keysched.sv
// des_keysched: per-round key halves rotation and round-key compression.
// Encrypt rotates left by the schedule amount of the current round. Decrypt
// rotates right by the amount mirrored from the end, with no rotation in the
// first round. Purely combinational; the caller registers c_out/d_out.
module des_keysched
    import des_pkg::*;
(
    input  logic [CD_W-1:0]     c_in,
    input  logic [CD_W-1:0]     d_in,
    input  rnd_t                rnd,
    input  logic                enc,
    output logic [CD_W-1:0]     c_out,
    output logic [CD_W-1:0]     d_out,
    output logic [SUBKEY_W-1:0] subkey
);

    rot_t                amt;
    rnd_t                mirror;
    logic [2*CD_W-1:0]   c_wide;
    logic [2*CD_W-1:0]   d_wide;
    logic [PC1_W-1:0]    cd_rot;

    // Pick the rotate amount for this round and direction.
    always_comb begin
        mirror = rnd_t'(NUM_ROUNDS - int'(rnd));
        if (enc)
            amt = rot_amount(rnd);
        else if (rnd == '0)
            amt = 2'd0;
        else
            amt = rot_amount(mirror);
    end

    // Rotate both halves through a doubled copy.
    always_comb begin
        if (enc) begin
            c_wide = {c_in, c_in} << amt;
            d_wide = {d_in, d_in} << amt;
            c_out  = c_wide[2*CD_W-1:CD_W];
            d_out  = d_wide[2*CD_W-1:CD_W];
        end else begin
            c_wide = {c_in, c_in} >> amt;
            d_wide = {d_in, d_in} >> amt;
            c_out  = c_wide[CD_W-1:0];
            d_out  = d_wide[CD_W-1:0];
        end
    end

    assign cd_rot = {c_out, d_out};

    for (genvar k = 1; k <= SUBKEY_W; k++) begin : g_pc2
        localparam int SRC = PC2_TAB[k-1];
        assign subkey[SUBKEY_W-k] = cd_rot[PC1_W-SRC];
    end

endmodule

// File: rtl/des_round.sv
// des_round: one Feistel step. It expands the right half, mixes in the round
// key, substitutes through the eight boxes, permutes, and XORs into the left
// half. Combinational; the caller registers the new halves.
module des_round
    import des_pkg::*;
(
    input  logic [HALF_W-1:0]   l_in,
    input  logic [HALF_W-1:0]   r_in,
    input  logic [SUBKEY_W-1:0] subkey,
    output logic [HALF_W-1:0]   l_out,
    output logic [HALF_W-1:0]   r_out
);

    logic [SUBKEY_W-1:0] expd;
    logic [SUBKEY_W-1:0] mixed;
    logic [HALF_W-1:0]   subst;
    logic [HALF_W-1:0]   fval;

    for (genvar k = 1; k <= SUBKEY_W; k++) begin : g_expand
        localparam int SRC = e_src(k);
        assign expd[SUBKEY_W-k] = r_in[HALF_W-SRC];
    end

    assign mixed = expd ^ subkey;

    for (genvar b = 0; b < NUM_SBOX; b++) begin : g_sbox
        logic [SBOX_IN_W-1:0] six;
        assign six = mixed[SUBKEY_W-1-SBOX_IN_W*b -: SBOX_IN_W];
        assign subst[HALF_W-1-SBOX_OUT_W*b -: SBOX_OUT_W] = sbox_lookup(3'(b), six);
    end

    for (genvar k = 1; k <= HALF_W; k++) begin : g_pperm
        localparam int SRC = P_TAB[k-1];
        assign fval[HALF_W-k] = subst[HALF_W-SRC];
    end

    assign l_out = r_in;
    assign r_out = l_in ^ fval;

endmodule

// File: rtl/des_parity.sv
// des_parity: odd-parity check over each key byte. The flag rises when the
// check is enabled and any byte has an even count of ones. Combinational.
module des_parity
    import des_pkg::*;
(
    input  logic             chk_en,
    input  logic [KEY_W-1:0] key,
    output logic             err
);

    logic [NUM_BYTES-1:0] even_byte;

    for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
        assign even_byte[b] = ~^key[BYTE_W*b +: BYTE_W];
    end

    assign err = chk_en & (|even_byte);

endmodule

// File: rtl/des_engine.sv
// des_engine: iterative DES, one round per enabled clock. The first round of
// a block reads the permuted key and data straight from the ports. Later
// rounds read the round registers. The last round writes the inverse-
// permuted result and raises the one-cycle valid strobe.
// Assumes enc_sel is steady for a whole block.
module des_engine
    import des_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             clr,
    input  logic             enc_sel,
    input  logic             par_chk_en,
    input  logic [KEY_W-1:0] key_in,
    input  logic [BLK_W-1:0] data_in,
    output logic [BLK_W-1:0] data_out,
    output logic             out_valid,
    output logic             par_err
);

    rnd_t                rnd_idx;
    logic                first_rnd;
    logic                last_rnd;

    logic [BLK_W-1:0]    ip_data;
    logic [PC1_W-1:0]    pc1_key;
    logic [BLK_W-1:0]    pre_out;
    logic [BLK_W-1:0]    fin_out;

    logic [CD_W-1:0]     c_q, d_q, c_cur, d_cur, c_nx, d_nx;
    logic [HALF_W-1:0]   l_q, r_q, l_cur, r_cur, l_nx, r_nx;
    logic [SUBKEY_W-1:0] subkey;
    logic [BLK_W-1:0]    q_q;
    logic                qv_q;

    des_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .clr       (clr),
        .rnd_idx   (rnd_idx),
        .first_rnd (first_rnd),
        .last_rnd  (last_rnd)
    );

    for (genvar j = 1; j <= BLK_W; j++) begin : g_ip
        localparam int SRC = ip_src(j);
        assign ip_data[BLK_W-j] = data_in[BLK_W-SRC];
        assign fin_out[BLK_W-SRC] = pre_out[BLK_W-j];
    end

    for (genvar k = 1; k <= PC1_W; k++) begin : g_pc1
        localparam int SRC = PC1_TAB[k-1];
        assign pc1_key[PC1_W-k] = key_in[KEY_W-SRC];
    end

    // Round input: fresh block from the ports on the first round, else the registers.
    always_comb begin
        if (first_rnd) begin
            c_cur = pc1_key[PC1_W-1:CD_W];
            d_cur = pc1_key[CD_W-1:0];
            l_cur = ip_data[BLK_W-1:HALF_W];
            r_cur = ip_data[HALF_W-1:0];
        end else begin
            c_cur = c_q;
            d_cur = d_q;
            l_cur = l_q;
            r_cur = r_q;
        end
    end

    des_keysched u_key (
        .c_in   (c_cur),
        .d_in   (d_cur),
        .rnd    (rnd_idx),
        .enc    (enc_sel),
        .c_out  (c_nx),
        .d_out  (d_nx),
        .subkey (subkey)
    );

    des_round u_round (
        .l_in   (l_cur),
        .r_in   (r_cur),
        .subkey (subkey),
        .l_out  (l_nx),
        .r_out  (r_nx)
    );

    assign pre_out = {r_nx, l_nx};

    // Round state, result and strobe: flush on clear, advance only when enabled.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q  <= '0;
            d_q  <= '0;
            l_q  <= '0;
            r_q  <= '0;
            q_q  <= '0;
            qv_q <= 1'b0;
        end else if (clr) begin
            c_q  <= '0;
            d_q  <= '0;
            l_q  <= '0;
            r_q  <= '0;
            q_q  <= '0;
            qv_q <= 1'b0;
        end else begin
            qv_q <= en & last_rnd;
            if (en) begin
                c_q <= c_nx;
                d_q <= d_nx;
                l_q <= l_nx;
                r_q <= r_nx;
                if (last_rnd)
                    q_q <= fin_out;
            end
        end
    end

    des_parity u_par (
        .chk_en (par_chk_en),
        .key    (key_in),
        .err    (par_err)
    );

    assign data_out  = q_q;
    assign out_valid = qv_q;

endmodule

// File: rtl/des_engine_chk.sv
// des_engine_chk: temporal checks on the engine's strobe, result hold,
// pause, clear and round stepping. Bound into des_engine below.
module des_engine_chk
    import des_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             clr,
    input  logic             pchk,
    input  logic             perr,
    input  logic             qval,
    input  logic [BLK_W-1:0] q,
    input  rnd_t             rnd
);

    localparam rnd_t LAST_IDX = rnd_t'(NUM_ROUNDS - 1);

    // R3
    qval_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        qval |=> !qval);

    // R3
    qval_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr && rnd == LAST_IDX) |=> qval);

    // R3
    q_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !(en && rnd == LAST_IDX)) |=> $stable(q));

    // R6
    pause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clr) |=> ($stable(rnd) && !qval));

    // R7
    clr_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (rnd == '0 && !qval && q == '0));

    // R9
    rnd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr && rnd != LAST_IDX) |=> (rnd == rnd_t'($past(rnd) + rnd_t'(1))));

    // R9
    rnd_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr && rnd == LAST_IDX) |=> (rnd == '0));

    // R5
    parity_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pchk |-> !perr);

endmodule

bind des_engine des_engine_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .clr   (clr),
    .pchk  (par_chk_en),
    .perr  (par_err),
    .qval  (out_valid),
    .q     (data_out),
    .rnd   (rnd_idx)
);

// File: tb/sim_des_engine.sv
// sim_des_engine: directed bench for des_engine. Inputs change and outputs
// are sampled on the falling edge.
module sim_des_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        clr = 1'b0;
    logic        enc_sel = 1'b1;
    logic        par_chk_en = 1'b0;
    logic [63:0] key_in = '0;
    logic [63:0] data_in = '0;
    logic [63:0] data_out;
    logic        out_valid;
    logic        par_err;

    int n_chk = 0;
    int n_err = 0;

    localparam logic [63:0] KA = 64'h133457799BBCDFF1;
    localparam logic [63:0] PA = 64'h0123456789ABCDEF;
    localparam logic [63:0] CA = 64'h85E813540F0AB405;
    localparam logic [63:0] KB = 64'h0E329232EA6D0D73;
    localparam logic [63:0] PB = 64'h8787878787878787;
    localparam logic [63:0] CB = 64'h0000000000000000;
    localparam logic [63:0] KC = 64'h0123456789ABCDEF;
    localparam logic [63:0] PC = 64'h4E6F772069732074;
    localparam logic [63:0] CC = 64'h3FA40E8A984D4815;
    localparam logic [63:0] KD = 64'h0101010101010101;
    localparam logic [63:0] PD = 64'h95F8A5E5DD31D900;
    localparam logic [63:0] CD = 64'h8000000000000000;
    localparam logic [63:0] PAR_FLIP = 64'h0101010101010101;

    always #4 clk = ~clk;

    des_engine u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .clr        (clr),
        .enc_sel    (enc_sel),
        .par_chk_en (par_chk_en),
        .key_in     (key_in),
        .data_in    (data_in),
        .data_out   (data_out),
        .out_valid  (out_valid),
        .par_err    (par_err)
    );

    task automatic chk64(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk1(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // One full block from idle, with strobe timing checked around the 16th edge.
    task automatic run_block(input logic [63:0] k, input logic [63:0] d, input logic dir,
                             input logic [63:0] exp, input string req);
        @(negedge clk);
        key_in = k; data_in = d; enc_sel = dir; en = 1'b1;
        repeat (15) @(negedge clk);
        chk1({req, " R3 no strobe before 16th edge"}, out_valid, 1'b0);
        @(negedge clk);
        chk1({req, " R3 strobe after 16th edge"}, out_valid, 1'b1);
        chk64(req, data_out, exp);
        en = 1'b0;
        @(negedge clk);
        chk1({req, " R3 strobe one cycle"}, out_valid, 1'b0);
    endtask

    task automatic t_reset_state();
        // R10
        chk1("R10 valid in reset", out_valid, 1'b0);
        chk64("R10 data_out in reset", data_out, 64'h0);
        chk1("R10 parity flag off", par_err, 1'b0);
    endtask

    task automatic t_encrypt();
        run_block(KA, PA, 1'b1, CA, "R1 encrypt vector A");
        run_block(KB, PB, 1'b1, CB, "R1 encrypt vector B");
        run_block(KC, PC, 1'b1, CC, "R1 encrypt vector C");
        run_block(KD, PD, 1'b1, CD, "R1 encrypt vector D");
    endtask

    task automatic t_decrypt();
        run_block(KA, CA, 1'b0, PA, "R2 decrypt vector A");
        run_block(KB, CB, 1'b0, PB, "R2 decrypt vector B");
        run_block(KC, CC, 1'b0, PC, "R2 decrypt vector C");
    endtask

    task automatic t_parity_bits_ignored();
        par_chk_en = 1'b0;
        run_block(KA ^ PAR_FLIP, PA, 1'b1, CA, "R4 flipped parity bits encrypt");
        chk1("R4 flag off with check disabled", par_err, 1'b0);
        run_block(KC ^ PAR_FLIP, CC, 1'b0, PC, "R4 flipped parity bits decrypt");
    endtask

    task automatic t_parity();
        @(negedge clk);
        par_chk_en = 1'b1; key_in = KA;
        #1 chk1("R5 good key", par_err, 1'b0);
        key_in = KA ^ PAR_FLIP;
        #1 chk1("R5 all bytes even", par_err, 1'b1);
        key_in = 64'h133457799BBCDFF0;
        #1 chk1("R5 last byte even", par_err, 1'b1);
        key_in = 64'h123457799BBCDFF1;
        #1 chk1("R5 first byte even", par_err, 1'b1);
        par_chk_en = 1'b0;
        #1 chk1("R5 check disabled", par_err, 1'b0);
    endtask

    task automatic t_pause();
        @(negedge clk);
        key_in = KB; data_in = PB; enc_sel = 1'b1; en = 1'b1;
        repeat (5) @(negedge clk);
        en = 1'b0;
        key_in = 64'hFFFF0000FFFF0000; data_in = 64'h0F0F0F0F0F0F0F0F;
        repeat (10) @(negedge clk);
        chk1("R6 no strobe while paused", out_valid, 1'b0);
        en = 1'b1;
        repeat (10) @(negedge clk);
        chk1("R6 no strobe before 16 enabled edges", out_valid, 1'b0);
        @(negedge clk);
        chk1("R6 strobe after resume", out_valid, 1'b1);
        // R8: inputs changed mid-block, result still from the sampled pair
        chk64("R8 R6 paused block result", data_out, CB);
        en = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_clear();
        @(negedge clk);
        key_in = KB; data_in = 64'hFFFFFFFFFFFFFFFF; enc_sel = 1'b1; en = 1'b1;
        repeat (7) @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        chk1("R7 strobe low after clear", out_valid, 1'b0);
        chk64("R7 result zeroed by clear", data_out, 64'h0);
        clr = 1'b0;
        key_in = KD; data_in = PD;
        repeat (15) @(negedge clk);
        chk1("R7 no strobe before 16 edges after clear", out_valid, 1'b0);
        @(negedge clk);
        chk1("R7 strobe for restarted block", out_valid, 1'b1);
        chk64("R7 restarted block result", data_out, CD);
        en = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_back_to_back();
        @(negedge clk);
        key_in = KA; data_in = PA; enc_sel = 1'b1; en = 1'b1;
        repeat (16) @(negedge clk);
        chk1("R9 first strobe", out_valid, 1'b1);
        chk64("R9 first result", data_out, CA);
        key_in = KC; data_in = CC; enc_sel = 1'b0;
        @(negedge clk);
        chk1("R9 strobe drops between blocks", out_valid, 1'b0);
        repeat (15) @(negedge clk);
        chk1("R9 second strobe 16 cycles later", out_valid, 1'b1);
        chk64("R9 second result", data_out, PC);
        en = 1'b0;
        key_in = KB; data_in = PB;
        repeat (5) @(negedge clk);
        // R3: result holds while idle
        chk64("R3 result held while idle", data_out, PC);
        chk1("R3 no strobe while idle", out_valid, 1'b0);
    endtask

    task automatic t_reset_midblock();
        @(negedge clk);
        key_in = KB; data_in = PB; enc_sel = 1'b1; en = 1'b1;
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk1("R10 async reset clears strobe", out_valid, 1'b0);
        chk64("R10 async reset clears result", data_out, 64'h0);
        en = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        run_block(KA, PA, 1'b1, CA, "R10 block after reset");
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog R1: actual still running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin : main
        repeat (2) @(negedge clk);
        t_reset_state();
        rst_n = 1'b1;
        t_encrypt();
        t_decrypt();
        t_parity_bits_ignored();
        t_parity();
        t_pause();
        t_clear();
        t_back_to_back();
        t_reset_midblock();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule